// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block holds a running time-of-day value made of a seconds count, a nanoseconds count and a fraction of a nanosecond. The value advances on every cycle of a 125 MHz clock by a programmable period. The period has an integer nanosecond part and a fraction resolved to 2^-32 ns. The fraction below 2^-8 ns is kept in a hidden accumulator, so a period that is not a whole number of nanoseconds adds no error over time.

Software steers the counter through three controls that all act on the same live value. It can load a new time outright. It can shift the time by a signed offset while the count keeps running. It can retune the period to trim the frequency. A read request copies every time field into a snapshot register in a single cycle, so the copy never mixes fields from both sides of a seconds rollover. A one-cycle strobe marks each tick on which the seconds count goes up.

Top module: `tod_clock_engine`

## Requirements
- R1: While reset is high, and on the first edge after it, the time is 0 s 0 ns 0, the period is 8.0 ns, the strobe is low, and the snapshot fields and the snapshot valid flag are all zero.
- R2: With no control active, each clock edge adds the period to the time. The period is 40 bits: bits 39:32 are whole nanoseconds and bits 31:0 are the fraction in units of 2^-32 ns. The nanoseconds wrap at 1,000,000,000 and carry into the 48-bit seconds. The fraction carries exactly, with no loss over any number of ticks.
- R3: The reported sub-nanosecond field is the time's fraction in units of 2^-8 ns, which are the top 8 bits of the 32-bit fraction accumulator.
- R4: A set strobe loads seconds, nanoseconds and sub-nanoseconds together at the next edge, with no period added on that edge. The hidden fraction bits below 2^-8 ns are cleared. The nanoseconds value written must be below 1,000,000,000.
- R5: A step strobe adds a 40-bit two's complement offset in units of 2^-8 ns to the time, on top of that edge's tick. It borrows from or carries into the seconds as needed, and it leaves the period unchanged. The offset magnitude must be below 1,000,000,000 ns.
- R6: When set and step strobe in the same cycle, the set is applied and the step is discarded.
- R7: A period write takes effect on the ticks after its edge. The tick on the edge of the write itself still uses the old period.
- R8: The strobe is high for exactly one cycle, the cycle in which the seconds first show an increase caused by a tick. A seconds change caused by a set or a step does not raise it.
- R9: A read request makes the snapshot hold, one cycle later, all time fields as they stood in the request cycle, with the valid flag high for that one cycle. Without a request, the snapshot holds its value and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz counter clock |
| rst | input | 1 | Synchronous reset, active high |
| set_en | input | 1 | Load the time from the set fields |
| set_sec | input | 48 | Seconds to load |
| set_ns | input | 30 | Nanoseconds to load |
| set_subns | input | 8 | Fraction to load, 2^-8 ns units |
| step_en | input | 1 | Add the offset to the running time |
| step_off | input | 40 | Signed offset, 2^-8 ns units |
| per_en | input | 1 | Replace the per-tick period |
| per_val | input | 40 | New period, 8.32 fixed point in ns |
| rd_req | input | 1 | Capture a snapshot of the time |
| snap_sec | output | 48 | Snapshot seconds |
| snap_ns | output | 30 | Snapshot nanoseconds |
| snap_subns | output | 8 | Snapshot fraction, 2^-8 ns units |
| snap_vld | output | 1 | Snapshot updated in this cycle |
| pps | output | 1 | Seconds incremented by a tick |

## Verification
On every cycle, the assertions check that the nanoseconds stay below one billion and that free-running seconds move by at most one. They also check that the strobe lasts one cycle and matches a seconds increment, that set fields and period writes land intact, that a step leaves the period alone, and that the snapshot equals the time of the request cycle. The arithmetic results can only be shown by the bench's scenarios, which compare against an exact wide-integer model. These results are fractional accumulation over a thousand ticks, borrows and carries from negative and positive steps, the edge on which a new period first counts, and the precedence of a set over a step in the same cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
    parameter int SEC_W     = 48;
    parameter int NS_W      = 30;
    parameter int SUB_W     = 8;
    parameter int FRAC_W    = 32;
    parameter int PER_INT_W = 8;
    parameter int ADJ_W     = 40;
    parameter int NS_PER_SEC = 1_000_000_000;

    localparam int PER_W = PER_INT_W + FRAC_W;
    localparam int LOW_W = FRAC_W - SUB_W;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    typedef struct packed {
        tod_t             tod;
        logic [PER_W-1:0] period;
        logic             pps;
        tod_t             snap;
        logic             snap_vld;
    } eng_state_t;
endpackage

// File: rtl/tod_tick_adder.sv
module tod_tick_adder
    import tod_pkg::*;
(
    input  tod_t             cur,
    input  logic [PER_W-1:0] period,
    output tod_t             nxt,
    output logic             sec_carry
);
    localparam logic [NS_W:0] BILLION = (NS_W+1)'(NS_PER_SEC);

    logic [FRAC_W:0] frac_sum;
    logic [NS_W:0]   ns_sum;

    always_comb begin
        frac_sum = {1'b0, cur.frac} + {1'b0, period[FRAC_W-1:0]};
        ns_sum   = {1'b0, cur.ns}
                 + (NS_W+1)'(period[PER_W-1:FRAC_W])
                 + (NS_W+1)'(frac_sum[FRAC_W]);
        nxt.frac  = frac_sum[FRAC_W-1:0];
        nxt.sec   = cur.sec;
        nxt.ns    = ns_sum[NS_W-1:0];
        sec_carry = 1'b0;
        if (ns_sum >= BILLION) begin
            nxt.ns    = NS_W'(ns_sum - BILLION);
            nxt.sec   = cur.sec + SEC_W'(1);
            sec_carry = 1'b1;
        end
    end
endmodule

// File: rtl/tod_offset_adder.sv
module tod_offset_adder
    import tod_pkg::*;
(
    input  tod_t             cur,
    input  logic [ADJ_W-1:0] off,
    output tod_t             nxt
);
    localparam int NSS_W = ADJ_W - SUB_W + 1;
    localparam logic signed [NSS_W-1:0] BILLION = NSS_W'(NS_PER_SEC);

    logic [SUB_W:0]           sub_sum;
    logic signed [NSS_W-1:0]  ns_s;

    always_comb begin
        sub_sum = {1'b0, cur.frac[FRAC_W-1:LOW_W]} + {1'b0, off[SUB_W-1:0]};
        ns_s    = $signed({{(NSS_W-NS_W){1'b0}}, cur.ns})
                + $signed({off[ADJ_W-1], off[ADJ_W-1:SUB_W]})
                + $signed({{(NSS_W-1){1'b0}}, sub_sum[SUB_W]});
        nxt.frac = {sub_sum[SUB_W-1:0], cur.frac[LOW_W-1:0]};
        nxt.sec  = cur.sec;
        nxt.ns   = ns_s[NS_W-1:0];
        if (ns_s[NSS_W-1]) begin
            nxt.ns  = NS_W'(ns_s + BILLION);
            nxt.sec = cur.sec - SEC_W'(1);
        end else if (ns_s >= BILLION) begin
            nxt.ns  = NS_W'(ns_s - BILLION);
            nxt.sec = cur.sec + SEC_W'(1);
        end
    end
endmodule

// File: rtl/tod_clock_engine.sv
module tod_clock_engine
    import tod_pkg::*;
#(
    parameter int NOMINAL_NS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [SEC_W-1:0] set_sec,
    input  logic [NS_W-1:0]  set_ns,
    input  logic [SUB_W-1:0] set_subns,
    input  logic             step_en,
    input  logic [ADJ_W-1:0] step_off,
    input  logic             per_en,
    input  logic [PER_W-1:0] per_val,
    input  logic             rd_req,
    output logic [SEC_W-1:0] snap_sec,
    output logic [NS_W-1:0]  snap_ns,
    output logic [SUB_W-1:0] snap_subns,
    output logic             snap_vld,
    output logic             pps
);
    localparam logic [PER_W-1:0] PERIOD_RST = {PER_INT_W'(NOMINAL_NS), {FRAC_W{1'b0}}};

    eng_state_t st_d, st_q;
    tod_t       ticked_d, stepped_d;
    logic       carry_d;

    tod_tick_adder u_tick (
        .cur       (st_q.tod),
        .period    (st_q.period),
        .nxt       (ticked_d),
        .sec_carry (carry_d)
    );

    tod_offset_adder u_step (
        .cur (ticked_d),
        .off (step_off),
        .nxt (stepped_d)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pps      = 1'b0;
        st_d.snap_vld = rd_req;
        if (rd_req) begin
            st_d.snap = st_q.tod;
        end
        if (per_en) begin
            st_d.period = per_val;
        end
        if (set_en) begin
            st_d.tod.sec  = set_sec;
            st_d.tod.ns   = set_ns;
            st_d.tod.frac = {set_subns, {LOW_W{1'b0}}};
        end else if (step_en) begin
            st_d.tod = stepped_d;
            st_d.pps = carry_d;
        end else begin
            st_d.tod = ticked_d;
            st_d.pps = carry_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.period <= PERIOD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_sec   = st_q.snap.sec;
    assign snap_ns    = st_q.snap.ns;
    assign snap_subns = st_q.snap.frac[FRAC_W-1:LOW_W];
    assign snap_vld   = st_q.snap_vld;
    assign pps        = st_q.pps;

    // R2: nanoseconds always below one second
    a_r2_ns_range: assert property (@(posedge clk) disable iff (rst)
        st_q.tod.ns < NS_W'(NS_PER_SEC));

    // R2: free-running seconds move by zero or one
    a_r2_sec_step: assert property (@(posedge clk) disable iff (rst)
        $past(!set_en && !step_en && !rst) |->
        (st_q.tod.sec == $past(st_q.tod.sec) ||
         st_q.tod.sec == $past(st_q.tod.sec) + SEC_W'(1)));

    // R4 and R6: set fields land intact, step ignored
    a_r4_set_load: assert property (@(posedge clk) disable iff (rst)
        $past(set_en && !rst) |->
        (st_q.tod.sec == $past(set_sec) && st_q.tod.ns == $past(set_ns) &&
         st_q.tod.frac == {$past(set_subns), {LOW_W{1'b0}}}));

    // R5: step does not touch the period
    a_r5_period_kept: assert property (@(posedge clk) disable iff (rst)
        $past(step_en && !per_en && !rst) |-> $stable(st_q.period));

    // R7: period write lands intact
    a_r7_period_load: assert property (@(posedge clk) disable iff (rst)
        $past(per_en && !rst) |-> st_q.period == $past(per_val));

    // R8: strobe lasts one cycle
    a_r8_pps_single: assert property (@(posedge clk) disable iff (rst)
        pps |=> !pps);

    // R8: strobe matches a seconds increment on a plain tick
    a_r8_pps_sec: assert property (@(posedge clk) disable iff (rst)
        (pps && $past(!set_en && !step_en && !rst)) |->
        st_q.tod.sec == $past(st_q.tod.sec) + SEC_W'(1));

    // R9: snapshot equals the time of the request cycle
    a_r9_snap_coherent: assert property (@(posedge clk) disable iff (rst)
        $past(rd_req && !rst) |->
        (snap_vld && st_q.snap == $past(st_q.tod)));
endmodule

// File: tb/test_tod_clock_engine.sv
`timescale 1ns/1ps
module test_tod_clock_engine;
    localparam time CLK_PERIOD = 8ns;
    localparam logic [127:0] BILL_SH = 128'(1_000_000_000) << 32;

    typedef struct packed {
        logic [47:0] sec;
        logic [29:0] ns;
        logic [7:0]  sub;
        logic [39:0] per;
        logic [39:0] off;
        logic [31:0] k;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{48'd0,   30'd0,           8'h00, {8'd8,   32'h0000_0000}, 40'd0,          32'd10},
        '{48'd7,   30'd999_999_990, 8'h00, {8'd8,   32'h0000_0000}, 40'd0,          32'd3},
        '{48'd100, 30'd5,           8'h80, {8'd8,   32'h5555_5555}, 40'd0,          32'd1000},
        '{48'd3,   30'd100,         8'h00, {8'd8,   32'h0000_0000}, -40'sd51200,    32'd2},
        '{48'd3,   30'd999_999_000, 8'h10, {8'd8,   32'h0000_0000}, 40'd512128,     32'd1},
        '{48'd9,   30'd999_999_999, 8'hFF, {8'd7,   32'hC000_0000}, 40'd0,          32'd5},
        '{48'd20,  30'd999_990_000, 8'h01, {8'd255, 32'hFFFF_FFFF}, 40'd0,          32'd20}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_en = 1'b0;
    logic [47:0] set_sec = '0;
    logic [29:0] set_ns = '0;
    logic [7:0]  set_subns = '0;
    logic        step_en = 1'b0;
    logic [39:0] step_off = '0;
    logic        per_en = 1'b0;
    logic [39:0] per_val = '0;
    logic        rd_req = 1'b0;
    logic [47:0] snap_sec;
    logic [29:0] snap_ns;
    logic [7:0]  snap_subns;
    logic        snap_vld;
    logic        pps;

    int n_chk = 0;
    int n_bad = 0;

    tod_clock_engine i_tod_clock_engine (
        .clk(clk), .rst(rst),
        .set_en(set_en), .set_sec(set_sec), .set_ns(set_ns), .set_subns(set_subns),
        .step_en(step_en), .step_off(step_off),
        .per_en(per_en), .per_val(per_val),
        .rd_req(rd_req),
        .snap_sec(snap_sec), .snap_ns(snap_ns), .snap_subns(snap_subns),
        .snap_vld(snap_vld), .pps(pps)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] tot_of(logic [47:0] s, logic [29:0] n, logic [7:0] sb);
        return ((128'(s) * 128'(1_000_000_000) + 128'(n)) << 32) + (128'(sb) << 24);
    endfunction

    function automatic logic [127:0] fields_of(logic [127:0] t);
        logic [127:0] r;
        r = t % BILL_SH;
        return {42'd0, 48'(t / BILL_SH), 30'(r >> 32), r[31:24]};
    endfunction

    function automatic logic [127:0] off_units(logic [39:0] o);
        return {{88{o[39]}}, o} << 24;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] snap_now();
        return {42'd0, snap_sec, snap_ns, snap_subns};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // set time (and optionally period) at one negedge; optional step on the next edge
    task automatic load(logic [47:0] s, logic [29:0] n, logic [7:0] sb,
                        bit wr_per, logic [39:0] p);
        set_en = 1'b1; set_sec = s; set_ns = n; set_subns = sb;
        per_en = wr_per; per_val = p;
        @(negedge clk);
        set_en = 1'b0; per_en = 1'b0;
    endtask

    task automatic read_after(int unsigned k_rest);
        repeat (k_rest) @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] exp;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pps/valid in reset", {126'd0, pps, snap_vld}, 128'd0);
        check("R1 snapshot in reset", snap_now(), 128'd0);
        rst = 1'b0;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check("R1 first snapshot after reset", {snap_now()[126:0], snap_vld}, {127'd0, 1'b1});
        read_after(4);
        check("R1 R2 default 8 ns period", snap_now(), fields_of(128'd40 << 32));

        // table of vectors: R2 R3 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            load(VECS[v].sec, VECS[v].ns, VECS[v].sub, 1'b1, VECS[v].per);
            step_en = (VECS[v].off != 40'd0);
            step_off = VECS[v].off;
            @(negedge clk);
            step_en = 1'b0;
            read_after(VECS[v].k - 1);
            exp = tot_of(VECS[v].sec, VECS[v].ns, VECS[v].sub)
                + 128'(VECS[v].k) * 128'(VECS[v].per) + off_units(VECS[v].off);
            check($sformatf("R2 R3 R5 vector %0d", v), snap_now(), fields_of(exp));
        end

        // R9: snapshot holds without a request
        repeat (3) @(negedge clk);
        check("R9 snapshot held, valid low", {snap_now()[126:0], snap_vld}, {fields_of(exp)[126:0], 1'b0});

        // R6: set and step together, step discarded
        set_en = 1'b1; set_sec = 48'd50; set_ns = 30'd1000; set_subns = 8'h00;
        per_en = 1'b1; per_val = {8'd8, 32'd0};
        step_en = 1'b1; step_off = 40'd256000;
        @(negedge clk);
        set_en = 1'b0; per_en = 1'b0; step_en = 1'b0;
        @(negedge clk);
        read_after(2);
        check("R6 set wins over step", snap_now(),
              fields_of(tot_of(48'd50, 30'd1000, 8'h00) + (128'd24 << 32)));

        // R7: new period counts only after its edge
        load(48'd60, 30'd0, 8'h00, 1'b1, {8'd8, 32'd0});
        per_en = 1'b1; per_val = {8'd10, 32'd0};
        @(negedge clk);
        per_en = 1'b0;
        read_after(4);
        check("R7 period takes effect next tick", snap_now(),
              fields_of(tot_of(48'd60, 30'd48, 8'h00)));

        // R8: strobe on tick rollover
        load(48'd5, 30'd999_999_992, 8'h00, 1'b1, {8'd8, 32'd0});
        check("R8 no strobe before rollover", {127'd0, pps}, 128'd0);
        @(negedge clk);
        check("R8 strobe on rollover", {127'd0, pps}, 128'd1);
        @(negedge clk);
        check("R8 strobe lasts one cycle", {127'd0, pps}, 128'd0);

        // R8: seconds change from a step gives no strobe
        load(48'd5, 30'd999_999_000, 8'h00, 1'b1, {8'd8, 32'd0});
        step_en = 1'b1; step_off = 40'd512000;
        @(negedge clk);
        step_en = 1'b0;
        check("R8 no strobe from step", {127'd0, pps}, 128'd0);
        read_after(0);
        check("R5 step carries into seconds", snap_now(),
              fields_of(tot_of(48'd6, 30'd1008, 8'h00)));

        finish_run();
    end
endmodule